// File: doc/BRIEF.md
# Multi-Queue Thread Block Dispatcher

This block assigns thread blocks from several ranked stream queues to a fixed set of multiprocessors. Each stream queue holds kernel descriptors in arrival order. A descriptor gives a block count and the warps, registers and shared-memory bytes that one block needs. The dispatcher keeps, for every multiprocessor, a running total of warps, registers, shared memory and resident blocks. It issues at most one block per clock and reports each issue as an event naming the stream, the kernel sequence number within that stream, the block index and the chosen multiprocessor.

Completion events name a stream and a multiprocessor. Such an event returns one block's worth of the stream's current kernel resources to that multiprocessor, and it takes effect in the same cycle's placement decision. A mode input selects between two orderings. Strict ordering holds back lower-ranked streams while a higher-ranked one still has blocks left to issue. Relaxed ordering lets any stream issue once every higher-ranked stream is unable to place a block. Stream 0 has the highest rank.

A descriptor whose single block could never fit on an empty multiprocessor is dropped. The block raises a one-cycle error event for it and does not stall.

Top module: `bdisp_top`

## Requirements
- R1: A block is placed on exactly one multiprocessor, and only if that multiprocessor then holds at most 64 warps, at most 65536 registers, at most 49152 shared-memory bytes and at most 16 blocks. Otherwise the block waits.
- R2: The target is the fitting multiprocessor (index 0 to 7) that holds the fewest resident blocks of the same kernel. Ties go to the lowest index, so a kernel issued from an empty machine lands on multiprocessor i mod 8 for block i.
- R3: A completion event frees its resources before the placement decision of the same cycle. A waiting block therefore appears on the freed multiprocessor in the dispatch event right after the completion is sampled.
- R4: Kernels of one stream issue in queue order. A kernel issues no block until every block of the previous kernel in that stream has completed. Kernel numbers count from 0 per stream after reset.
- R5: With strict_mode = 1, a stream issues nothing while any higher-ranked stream still has an unissued block, including blocks of kernels queued behind its head.
- R6: With strict_mode = 0, the highest-ranked stream that can place a block wins the cycle. A lower-ranked stream issues as soon as all higher-ranked ones cannot place.
- R7: A descriptor with more than 64 warps, more than 65536 registers or more than 49152 shared-memory bytes per block is removed with a one-cycle err_valid pulse that carries its stream and kernel number. The next kernel of that stream then proceeds.
- R8: At most one dispatch event occurs per clock. The blocks of one kernel are issued with indices 0, 1, 2 … in consecutive cycles while they fit.
- R9: After reset, disp_valid and err_valid are 0 and every multiprocessor is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strict_mode | input | 1 | 1 = strict rank ordering, 0 = relaxed |
| push_valid | input | 1 | Append a descriptor to a stream queue |
| push_stream | input | 2 | Target stream of the descriptor |
| push_blocks | input | 8 | Number of blocks in the kernel |
| push_warps | input | 7 | Warps per block |
| push_regs | input | 17 | Registers per block |
| push_smem | input | 16 | Shared-memory bytes per block |
| cmp_valid | input | 1 | A block has completed |
| cmp_stream | input | 2 | Stream of the completed block |
| cmp_sm | input | 3 | Multiprocessor of the completed block |
| disp_valid | output | 1 | Dispatch event |
| disp_stream | output | 2 | Stream of the dispatched block |
| disp_kernel | output | 4 | Kernel sequence number in the stream |
| disp_block | output | 8 | Block index within the kernel |
| disp_sm | output | 3 | Target multiprocessor |
| err_valid | output | 1 | Oversized descriptor rejected |
| err_stream | output | 2 | Stream of the rejected descriptor |
| err_kernel | output | 4 | Kernel number of the rejected descriptor |

## Verification
A completion and a placement can fall in the same cycle, and the completion must win the race for the freed space. The bench provokes this by filling every multiprocessor with register-heavy blocks so that one block is left waiting. It then sends a single completion for multiprocessor 5. The case passes only if the next dispatch event appears in the cycle right after the completion is sampled and names multiprocessor 5 with block index 8.

// File: rtl/bdisp_pkg.sv
package bdisp_pkg;
  localparam int MAX_WARPS  = 64;
  localparam int MAX_REGS   = 65536;
  localparam int MAX_SMEM   = 49152;
  localparam int MAX_BLOCKS = 16;

  localparam int BLK_W = 8;
  localparam int WRP_W = 7;
  localparam int REG_W = 17;
  localparam int SHM_W = 16;
  localparam int RES_W = $clog2(MAX_BLOCKS + 1);

  typedef struct packed {
    logic [BLK_W-1:0] blocks;
    logic [WRP_W-1:0] warps;
    logic [REG_W-1:0] regs;
    logic [SHM_W-1:0] smem;
  } desc_t;

  typedef struct packed {
    logic [WRP_W-1:0] warps;
    logic [REG_W-1:0] regs;
    logic [SHM_W-1:0] smem;
    logic [RES_W-1:0] blocks;
  } usage_t;

  // True when one more block of d can join a multiprocessor holding u.
  function automatic logic fits(input usage_t u, input desc_t d);
    return (32'(u.warps) + 32'(d.warps) <= MAX_WARPS) &&
           (32'(u.regs)  + 32'(d.regs)  <= MAX_REGS)  &&
           (32'(u.smem)  + 32'(d.smem)  <= MAX_SMEM)  &&
           (32'(u.blocks) < MAX_BLOCKS);
  endfunction

  function automatic logic never_fits(input desc_t d);
    return !fits('0, d);
  endfunction
endpackage

// File: rtl/bdisp_queue.sv
module bdisp_queue import bdisp_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  desc_t            push_d,
  input  logic             pop,
  output desc_t            head,
  output logic             head_valid,
  output logic [CNT_W-1:0] count
);
  desc_t mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic do_push, do_pop;

  assign do_push = push && (count != CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assign head       = mem[rd_ptr];
  assign head_valid = (count != '0);
endmodule

// File: rtl/bdisp_sm_ledger.sv
module bdisp_sm_ledger import bdisp_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel,
  input  logic [WRP_W-1:0] rel_warps,
  input  logic [REG_W-1:0] rel_regs,
  input  logic [SHM_W-1:0] rel_smem,
  input  logic             add,
  input  logic [WRP_W-1:0] add_warps,
  input  logic [REG_W-1:0] add_regs,
  input  logic [SHM_W-1:0] add_smem,
  output usage_t           eff
);
  usage_t cur, nxt;

  // Usage seen by the placement decision: completion already applied.
  always_comb begin
    eff = cur;
    if (rel) begin
      eff.warps  = cur.warps - rel_warps;
      eff.regs   = cur.regs - rel_regs;
      eff.smem   = cur.smem - rel_smem;
      eff.blocks = cur.blocks - RES_W'(1);
    end
    nxt = eff;
    if (add) begin
      nxt.warps  = eff.warps + add_warps;
      nxt.regs   = eff.regs + add_regs;
      nxt.smem   = eff.smem + add_smem;
      nxt.blocks = eff.blocks + RES_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  a_r1_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cur.warps) <= MAX_WARPS) && (32'(cur.regs) <= MAX_REGS) &&
    (32'(cur.smem) <= MAX_SMEM) && (32'(cur.blocks) <= MAX_BLOCKS));

  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !add) |=> (cur.warps == $past(cur.warps) - $past(rel_warps)) &&
                      (cur.regs == $past(cur.regs) - $past(rel_regs)));
endmodule

// File: rtl/bdisp_top.sv
module bdisp_top import bdisp_pkg::*; #(
  parameter int NUM_SM      = 8,
  parameter int NUM_STREAMS = 3,
  parameter int QDEPTH      = 4,
  parameter int KID_W       = 4,
  localparam int SM_W   = $clog2(NUM_SM),
  localparam int SID_W  = $clog2(NUM_STREAMS),
  localparam int QCNT_W = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strict_mode,
  input  logic             push_valid,
  input  logic [SID_W-1:0] push_stream,
  input  logic [BLK_W-1:0] push_blocks,
  input  logic [WRP_W-1:0] push_warps,
  input  logic [REG_W-1:0] push_regs,
  input  logic [SHM_W-1:0] push_smem,
  input  logic             cmp_valid,
  input  logic [SID_W-1:0] cmp_stream,
  input  logic [SM_W-1:0]  cmp_sm,
  output logic             disp_valid,
  output logic [SID_W-1:0] disp_stream,
  output logic [KID_W-1:0] disp_kernel,
  output logic [BLK_W-1:0] disp_block,
  output logic [SM_W-1:0]  disp_sm,
  output logic             err_valid,
  output logic [SID_W-1:0] err_stream,
  output logic [KID_W-1:0] err_kernel
);
  desc_t                    push_d;
  desc_t                    hd      [NUM_STREAMS];
  logic [QCNT_W-1:0]        qcnt    [NUM_STREAMS];
  logic [NUM_STREAMS-1:0]   hv, pop;
  logic [BLK_W-1:0]         issued  [NUM_STREAMS];
  logic [BLK_W-1:0]         outst   [NUM_STREAMS];
  logic [KID_W-1:0]         kid     [NUM_STREAMS];
  logic [RES_W-1:0]         res_cnt [NUM_STREAMS][NUM_SM];
  logic [RES_W-1:0]         cnt_eff [NUM_STREAMS][NUM_SM];
  usage_t                   eff_u   [NUM_SM];
  logic [NUM_SM-1:0]        fitv    [NUM_STREAMS];
  // Named decision events, observed by the assertions.
  logic [NUM_STREAMS-1:0]   oversize, remaining, ready, can, done, above_mask;
  logic                     go, blocked, found, err_go;
  logic [SID_W-1:0]         sel, err_sel;
  logic [SM_W-1:0]          tgt;
  logic [RES_W-1:0]         best;

  assign push_d = '{blocks: push_blocks, warps: push_warps, regs: push_regs, smem: push_smem};

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_q
    bdisp_queue #(.DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push(push_valid && (push_stream == SID_W'(s))), .push_d(push_d),
      .pop(pop[s]), .head(hd[s]), .head_valid(hv[s]), .count(qcnt[s]));
  end

  for (genvar m = 0; m < NUM_SM; m++) begin : g_sm
    bdisp_sm_ledger u_led (
      .clk(clk), .rst_n(rst_n),
      .rel(cmp_valid && (cmp_sm == SM_W'(m))),
      .rel_warps(hd[cmp_stream].warps), .rel_regs(hd[cmp_stream].regs),
      .rel_smem(hd[cmp_stream].smem),
      .add(go && (tgt == SM_W'(m))),
      .add_warps(hd[sel].warps), .add_regs(hd[sel].regs), .add_smem(hd[sel].smem),
      .eff(eff_u[m]));
  end

  always_comb begin
    for (int s = 0; s < NUM_STREAMS; s++) begin
      oversize[s]  = hv[s] && never_fits(hd[s]);
      remaining[s] = hv[s] && ((qcnt[s] > QCNT_W'(1)) || (issued[s] < hd[s].blocks));
      ready[s]     = hv[s] && !oversize[s] && (issued[s] < hd[s].blocks);
      done[s]      = hv[s] && !oversize[s] && (issued[s] == hd[s].blocks) && (outst[s] == '0);
      for (int m = 0; m < NUM_SM; m++) begin
        cnt_eff[s][m] = res_cnt[s][m] - RES_W'(cmp_valid && (cmp_stream == SID_W'(s)) &&
                                               (cmp_sm == SM_W'(m)));
        fitv[s][m]    = ready[s] && fits(eff_u[m], hd[s]);
      end
      can[s] = |fitv[s];
    end
    // Stream choice: rank order; strict mode stops at the first stream with work.
    go = 1'b0; blocked = 1'b0; sel = '0;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      if (!go && !blocked) begin
        if (can[s]) begin go = 1'b1; sel = SID_W'(s); end
        else if (strict_mode && remaining[s]) blocked = 1'b1;
      end
    end
    for (int s = 0; s < NUM_STREAMS; s++) above_mask[s] = (SID_W'(s) < sel);
    // Breadth-first target: fewest resident blocks of this kernel, lowest index.
    found = 1'b0; tgt = '0; best = '0;
    for (int m = 0; m < NUM_SM; m++) begin
      if (fitv[sel][m] && (!found || (cnt_eff[sel][m] < best))) begin
        found = 1'b1; tgt = SM_W'(m); best = cnt_eff[sel][m];
      end
    end
    err_go = 1'b0; err_sel = '0;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      if (!err_go && oversize[s]) begin err_go = 1'b1; err_sel = SID_W'(s); end
    end
    for (int s = 0; s < NUM_STREAMS; s++)
      pop[s] = done[s] || (err_go && (err_sel == SID_W'(s)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0; disp_stream <= '0; disp_kernel <= '0;
      disp_block <= '0;   disp_sm <= '0;
      err_valid  <= 1'b0; err_stream <= '0;  err_kernel <= '0;
      for (int s = 0; s < NUM_STREAMS; s++) begin
        issued[s] <= '0; outst[s] <= '0; kid[s] <= '0;
        for (int m = 0; m < NUM_SM; m++) res_cnt[s][m] <= '0;
      end
    end else begin
      disp_valid <= go;
      if (go) begin
        disp_stream <= sel;
        disp_kernel <= kid[sel];
        disp_block  <= issued[sel];
        disp_sm     <= tgt;
      end
      err_valid <= err_go;
      if (err_go) begin
        err_stream <= err_sel;
        err_kernel <= kid[err_sel];
      end
      for (int s = 0; s < NUM_STREAMS; s++) begin
        if (pop[s]) begin
          issued[s] <= '0;
          outst[s]  <= '0;
          kid[s]    <= kid[s] + 1'b1;
          for (int m = 0; m < NUM_SM; m++) res_cnt[s][m] <= '0;
        end else begin
          issued[s] <= issued[s] + BLK_W'(go && (sel == SID_W'(s)));
          outst[s]  <= outst[s] + BLK_W'(go && (sel == SID_W'(s)))
                                - BLK_W'(cmp_valid && (cmp_stream == SID_W'(s)));
          for (int m = 0; m < NUM_SM; m++)
            res_cnt[s][m] <= cnt_eff[s][m] +
                             RES_W'(go && (sel == SID_W'(s)) && (tgt == SM_W'(m)));
        end
      end
    end
  end

  a_r1_target_fits: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> fitv[sel][tgt]);

  a_r5_strict_rank: assert property (@(posedge clk) disable iff (!rst_n)
    (go && strict_mode) |-> ((remaining & above_mask) == '0));

  a_r7_err_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && disp_valid) |-> (err_stream != disp_stream));

  a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && $past(disp_valid) && (disp_stream == $past(disp_stream)) &&
     (disp_kernel == $past(disp_kernel))) |-> (disp_block == $past(disp_block) + 1'b1));
endmodule

// File: tb/bdisp_top_test.sv
module bdisp_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strict_mode = 1'b1;
  logic        push_valid = 1'b0;
  logic [1:0]  push_stream = '0;
  logic [7:0]  push_blocks = '0;
  logic [6:0]  push_warps = '0;
  logic [16:0] push_regs = '0;
  logic [15:0] push_smem = '0;
  logic        cmp_valid = 1'b0;
  logic [1:0]  cmp_stream = '0;
  logic [2:0]  cmp_sm = '0;
  logic        disp_valid, err_valid;
  logic [1:0]  disp_stream, err_stream;
  logic [3:0]  disp_kernel, err_kernel;
  logic [7:0]  disp_block;
  logic [2:0]  disp_sm;

  bdisp_top uut (
    .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
    .push_valid(push_valid), .push_stream(push_stream), .push_blocks(push_blocks),
    .push_warps(push_warps), .push_regs(push_regs), .push_smem(push_smem),
    .cmp_valid(cmp_valid), .cmp_stream(cmp_stream), .cmp_sm(cmp_sm),
    .disp_valid(disp_valid), .disp_stream(disp_stream), .disp_kernel(disp_kernel),
    .disp_block(disp_block), .disp_sm(disp_sm),
    .err_valid(err_valid), .err_stream(err_stream), .err_kernel(err_kernel));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Event log filled at the falling edge.
  int ev_n = 0;
  int ev_s [1024], ev_k [1024], ev_b [1024], ev_m [1024], ev_c [1024];
  int err_n = 0, err_s = -1, err_k = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (disp_valid && ev_n < 1024) begin
        ev_s[ev_n] = int'(disp_stream); ev_k[ev_n] = int'(disp_kernel);
        ev_b[ev_n] = int'(disp_block);  ev_m[ev_n] = int'(disp_sm);
        ev_c[ev_n] = cyc;
        ev_n = ev_n + 1;
      end
      if (err_valid) begin
        err_n = err_n + 1; err_s = int'(err_stream); err_k = int'(err_kernel);
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit strict);
    @(negedge clk);
    rst_n = 1'b0; strict_mode = strict; push_valid = 1'b0; cmp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input int s, input int b, input int w, input int r, input int m);
    @(negedge clk);
    push_valid = 1'b1; push_stream = 2'(s); push_blocks = 8'(b);
    push_warps = 7'(w); push_regs = 17'(r); push_smem = 16'(m);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  int cmp_cyc = 0;
  task automatic complete(input int s, input int m);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_stream = 2'(s); cmp_sm = 3'(m); cmp_cyc = cyc;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  // blocks, warps, registers, shared bytes, blocks expected to be placed
  localparam int ROWS = 6;
  localparam int VEC [ROWS][5] = '{
    '{ 10, 32, 16384,     0,  10},
    '{  9, 32, 40960,     0,   8},
    '{  9,  8,  1024, 24577,   8},
    '{136,  1,    32,     0, 128},
    '{ 24, 24,   100,     0,  16},
    '{  9, 64, 65536, 49152,   8}};

  initial begin : watchdog
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int base, ebase, cnt, idx9, idx1;
    bit ok;
    // R9: reset state
    do_reset(1'b1);
    @(negedge clk);
    check(disp_valid == 1'b0, "R9 disp_valid", int'(disp_valid), 0);
    check(err_valid == 1'b0, "R9 err_valid", int'(err_valid), 0);

    // R1 / R2 / R8: capacity limits and breadth-first placement from the table
    for (int row = 0; row < ROWS; row++) begin
      do_reset(1'b1);
      base = ev_n;
      push(0, VEC[row][0], VEC[row][1], VEC[row][2], VEC[row][3]);
      repeat (200) @(negedge clk);
      cnt = ev_n - base;
      check(cnt == VEC[row][4], "R1 placed count", cnt, VEC[row][4]);
      ok = 1'b1;
      for (int i = 0; i < cnt; i++)
        if (ev_s[base+i] != 0 || ev_b[base+i] != i || ev_m[base+i] != i % 8) ok = 1'b0;
      check(ok, "R2 target order", row, row);
      if (row == 0) begin
        ok = 1'b1;
        for (int i = 1; i < cnt; i++) if (ev_c[base+i] != ev_c[base] + i) ok = 1'b0;
        check(ok, "R8 one per cycle", ev_c[base+cnt-1] - ev_c[base], cnt - 1);
      end
      if (row == 1) begin
        // R3: completion and placement in the same cycle
        complete(0, 5);
        repeat (3) @(negedge clk);
        check(ev_n - base == 9, "R3 backfill count", ev_n - base, 9);
        check(ev_m[base+8] == 5 && ev_b[base+8] == 8, "R3 backfill sm", ev_m[base+8], 5);
        check(ev_c[base+8] == cmp_cyc + 1, "R3 same cycle", ev_c[base+8], cmp_cyc + 1);
      end
    end

    // R4: in-order kernels within a stream
    do_reset(1'b1);
    base = ev_n;
    push(0, 2, 1, 32, 0);
    push(0, 1, 1, 32, 0);
    repeat (20) @(negedge clk);
    check(ev_n - base == 2, "R4 first kernel only", ev_n - base, 2);
    complete(0, 0);
    repeat (20) @(negedge clk);
    check(ev_n - base == 2, "R4 waits for last block", ev_n - base, 2);
    complete(0, 1);
    repeat (20) @(negedge clk);
    check(ev_n - base == 3, "R4 next kernel count", ev_n - base, 3);
    check(ev_k[base+2] == 1 && ev_b[base+2] == 0 && ev_m[base+2] == 0,
          "R4 next kernel id", ev_k[base+2], 1);

    // R5: strict rank ordering
    do_reset(1'b1);
    base = ev_n;
    push(0, 10, 32, 40960, 0);
    push(1, 1, 1, 32, 0);
    repeat (40) @(negedge clk);
    cnt = 0;
    for (int i = base; i < ev_n; i++) if (ev_s[i] == 1) cnt++;
    check(cnt == 0 && ev_n - base == 8, "R5 lower stream held", cnt, 0);
    complete(0, 0);
    complete(0, 1);
    repeat (20) @(negedge clk);
    idx9 = -1; idx1 = -1;
    for (int i = base; i < ev_n; i++) begin
      if (ev_s[i] == 0 && ev_b[i] == 9) idx9 = i;
      if (ev_s[i] == 1) idx1 = i;
    end
    check(idx9 >= 0 && idx1 > idx9, "R5 order after release", idx1, idx9 + 1);

    // R6: relaxed ordering
    do_reset(1'b0);
    base = ev_n;
    push(0, 10, 32, 40960, 0);
    push(1, 1, 1, 32, 0);
    repeat (40) @(negedge clk);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) if (ev_s[base+i] != 0) ok = 1'b0;
    check(ok, "R6 higher rank first", ev_s[base], 0);
    check(ev_n - base == 9 && ev_s[base+8] == 1 && ev_m[base+8] == 0,
          "R6 lower stream passes", ev_s[base+8], 1);

    // R7: oversized descriptors
    do_reset(1'b1);
    base = ev_n; ebase = err_n;
    push(0, 3, 65, 32, 0);
    push(0, 1, 1, 32, 0);
    repeat (20) @(negedge clk);
    check(err_n - ebase == 1 && err_s == 0 && err_k == 0, "R7 warp error", err_n - ebase, 1);
    check(ev_n - base == 1 && ev_k[base] == 1 && ev_b[base] == 0,
          "R7 next kernel runs", ev_k[base], 1);
    push(1, 2, 1, 65537, 0);
    repeat (10) @(negedge clk);
    check(err_n - ebase == 2 && err_s == 1 && err_k == 0, "R7 register error", err_s, 1);
    check(ev_n - base == 1, "R7 no dispatch", ev_n - base, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule